// File: doc/BRIEF.md
# Display Scan Timing Generator with Double-Buffered Base Select

This block produces the horizontal and vertical scan timing for a single display pipe. Two counters walk the raster. X advances every cycle and Y advances when X wraps. From their values the block derives a data-enable window, an hsync output and a vsync output. Each sync output has its own window, its own enable and its own polarity. The live position and a running count of vertical blanks can be read back through a small register port.

The block holds two frame-buffer base addresses and drives the selected one on `fb_base_o`. Software requests a swap by writing the flip bit. The swap does not happen at once: a two-state machine (FLIP_IDLE, FLIP_PENDING) holds the request until the next vertical-blank event and only then toggles the select. The transitions are:
- FLIP_IDLE to FLIP_PENDING on a flip write.
- FLIP_PENDING to FLIP_IDLE on a vertical blank, which toggles the select.
- Any state to FLIP_IDLE on a soft reset, which also returns the select to base 0.

Two sticky status bits record hsync and vsync events. Each one raises `irq_o` only when its enable bit is set.

Top module: `scan_pipe`

## Requirements
- R1: After `rst_n` is released the control word (address 0) reads 0x2 (run bit set, output enable clear, select 0, nothing pending). The position, the blank count and the status read 0, `irq_o` and `de_o` are 0, and `fb_base_o` is 0.
- R2: While running (control bit0 = 1 and bit1 = 1), X counts from 0 to the last-X field (address 1, bits 28:16) and then returns to 0. Y steps by one each time X returns to 0, and goes back to 0 after the last-Y field (address 2, bits 27:16). Address 7 reads X in bits 31:16 and Y in bits 15:0.
- R3: `hsync_o` equals the invert bit (address 3, bit 31) XOR the window condition. The window condition is: running, enable bit 30 set, and X >= start (bits 12:0) and X < end (bits 28:16).
- R4: `vsync_o` is formed the same way from Y and address 4: start in bits 11:0, end in bits 27:16, enable bit 30, invert bit 31.
- R5: A vertical-blank event occurs in a running cycle where X equals last-X and Y + 1 equals the active-line field (address 2, bits 11:0). The counter at address 8 then increments by one on the following edge.
- R6: Writing control bit2 = 1 sets the pending flag (control bit4). At the next vertical-blank event the select (control bit3) toggles and the pending flag clears. `fb_base_o` then follows base 0 (address 5) or base 1 (address 6) according to the select. A later flip write swaps back.
- R7: A flip write while the pending flag is set does not add a second swap. A flip write in the same cycle as the event that consumes a pending flip is dropped.
- R8: In a running cycle, status bit0 (address 9) sets when X equals the hsync start. Status bit1 sets when X = 0 and Y equals the vsync start. Writing 1 to a status bit clears it, and a set in the same cycle wins. `irq_o` is the OR of each status bit ANDed with its enable (bits 16 and 17).
- R9: While control bit0 is 0 the counters hold. `hsync_o` and `vsync_o` then sit at their invert levels, and `de_o` is 0.
- R10: Writing control bit1 = 0 while it is 1 clears X, Y, the blank count, the status bits, the pending flag and the select. While bit1 stays 0 the counters hold. Timing registers, bases and enables keep their values.
- R11: `de_o` is 1 exactly when running, X < active-pixel field (address 1, bits 12:0) and Y < active-line field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipe clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Active-region data enable |
| irq_o | output | 1 | Enabled sync interrupt |
| fb_base_o | output | 32 | Frame-buffer base currently in use |

## Verification
A wrong counter state shows up at `reg_rdata` for address 7 and on `de_o` and the sync pins in the same cycle. It then shifts every following event. A stuck or double-counted flip request appears on `fb_base_o` and control bits 3 and 4 within one frame of the flip write. A missed or duplicate vertical-blank event changes the address-8 count within a frame. A status bit that fails to set or clear shows on `irq_o` one cycle after the event or the clearing write.

// File: rtl/scan_pkg.sv
package scan_pkg;
    localparam int ADDR_W   = 4;
    localparam int FIELD_HI = 16;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_HTIME = 4'd1;
    localparam logic [ADDR_W-1:0] A_VTIME = 4'd2;
    localparam logic [ADDR_W-1:0] A_HSYNC = 4'd3;
    localparam logic [ADDR_W-1:0] A_VSYNC = 4'd4;
    localparam logic [ADDR_W-1:0] A_BASE0 = 4'd5;
    localparam logic [ADDR_W-1:0] A_BASE1 = 4'd6;
    localparam logic [ADDR_W-1:0] A_POS   = 4'd7;
    localparam logic [ADDR_W-1:0] A_VBCNT = 4'd8;
    localparam logic [ADDR_W-1:0] A_IRQ   = 4'd9;

    localparam int B_OUTEN    = 0;
    localparam int B_RUN      = 1;
    localparam int B_FLIP     = 2;
    localparam int B_SEL      = 3;
    localparam int B_PEND     = 4;
    localparam int B_SYNC_EN  = 30;
    localparam int B_SYNC_INV = 31;

    typedef enum logic {
        FLIP_IDLE    = 1'b0,
        FLIP_PENDING = 1'b1
    } flip_state_e;
endpackage

// File: rtl/scan_sync.sv
module scan_sync #(
    parameter int W = 13
) (
    input  logic         run,
    input  logic [W-1:0] pos,
    input  logic [W-1:0] start_pos,
    input  logic [W-1:0] end_pos,
    input  logic         en,
    input  logic         inv,
    output logic         level
);
    logic in_win;

    always_comb begin
        in_win = run && en && (pos >= start_pos) && (pos < end_pos);
        level  = in_win ^ inv;
    end
endmodule

// File: rtl/scan_timing.sv
module scan_timing #(
    parameter int HW = 13,
    parameter int VW = 12,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          soft_clr,
    input  logic [HW-1:0] hactive,
    input  logic [HW-1:0] hlast,
    input  logic [HW-1:0] hs_start,
    input  logic [HW-1:0] hs_end,
    input  logic          hs_en,
    input  logic          hs_inv,
    input  logic [VW-1:0] vactive,
    input  logic [VW-1:0] vlast,
    input  logic [VW-1:0] vs_start,
    input  logic [VW-1:0] vs_end,
    input  logic          vs_en,
    input  logic          vs_inv,
    output logic [HW-1:0] pos_x,
    output logic [VW-1:0] pos_y,
    output logic [CW-1:0] vbcount,
    output logic          hs_evt,
    output logic          vs_evt,
    output logic          vb_evt,
    output logic          hsync,
    output logic          vsync,
    output logic          de
);
    logic        x_wrap;
    logic        y_wrap;
    logic [VW:0] y_inc;

    always_comb begin
        x_wrap = (pos_x == hlast);
        y_wrap = (pos_y == vlast);
        y_inc  = {1'b0, pos_y} + 1'b1;
        hs_evt = run && (pos_x == hs_start);
        vs_evt = run && (pos_x == '0) && (pos_y == vs_start);
        vb_evt = run && x_wrap && (y_inc == {1'b0, vactive});
        de     = run && (pos_x < hactive) && (pos_y < vactive);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_x   <= '0;
            pos_y   <= '0;
            vbcount <= '0;
        end else if (soft_clr) begin
            pos_x   <= '0;
            pos_y   <= '0;
            vbcount <= '0;
        end else begin
            if (run) begin
                pos_x <= x_wrap ? '0 : pos_x + 1'b1;
                if (x_wrap) begin
                    pos_y <= y_wrap ? '0 : pos_y + 1'b1;
                end
            end
            if (vb_evt) begin
                vbcount <= vbcount + 1'b1;
            end
        end
    end

    // One comparator per axis; the axis width picks the variant.
    scan_sync #(.W(HW)) u_hsync (
        .run(run), .pos(pos_x), .start_pos(hs_start), .end_pos(hs_end),
        .en(hs_en), .inv(hs_inv), .level(hsync)
    );

    scan_sync #(.W(VW)) u_vsync (
        .run(run), .pos(pos_y), .start_pos(vs_start), .end_pos(vs_end),
        .en(vs_en), .inv(vs_inv), .level(vsync)
    );
endmodule

// File: rtl/scan_flip.sv
module scan_flip
    import scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic flip_req,
    input  logic vb_evt,
    output logic sel,
    output logic pending
);
    flip_state_e state_q;
    flip_state_e state_d;
    logic        sel_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLIP_IDLE;
            sel     <= 1'b0;
        end else begin
            state_q <= state_d;
            sel     <= sel_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sel_d   = sel;
        if (soft_clr) begin
            state_d = FLIP_IDLE;
            sel_d   = 1'b0;
        end else begin
            unique case (state_q)
                FLIP_IDLE: begin
                    if (flip_req) state_d = FLIP_PENDING;
                end
                FLIP_PENDING: begin
                    if (vb_evt) begin
                        state_d = FLIP_IDLE;
                        sel_d   = ~sel;
                    end
                end
                default: state_d = FLIP_IDLE;
            endcase
        end
    end

    assign pending = (state_q == FLIP_PENDING);
endmodule

// File: rtl/scan_regs.sv
module scan_regs
    import scan_pkg::*;
#(
    parameter int HW = 13,
    parameter int VW = 12,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [HW-1:0]     pos_x,
    input  logic [VW-1:0]     pos_y,
    input  logic              sel,
    input  logic              pending,
    input  logic [DW-1:0]     vbcount,
    input  logic              hs_evt,
    input  logic              vs_evt,
    output logic              out_en,
    output logic              pipe_on,
    output logic              soft_clr,
    output logic              flip_req,
    output logic [HW-1:0]     hactive,
    output logic [HW-1:0]     hlast,
    output logic [HW-1:0]     hs_start,
    output logic [HW-1:0]     hs_end,
    output logic              hs_en,
    output logic              hs_inv,
    output logic [VW-1:0]     vactive,
    output logic [VW-1:0]     vlast,
    output logic [VW-1:0]     vs_start,
    output logic [VW-1:0]     vs_end,
    output logic              vs_en,
    output logic              vs_inv,
    output logic [DW-1:0]     base0,
    output logic [DW-1:0]     base1,
    output logic [1:0]        irq_en,
    output logic [1:0]        irq_stat,
    output logic              irq_o
);
    logic       wr_ctrl;
    logic [1:0] stat_clr;
    logic       unused_wdata;

    assign wr_ctrl      = wr && (addr == A_CTRL);
    assign soft_clr     = wr_ctrl && pipe_on && !wdata[B_RUN];
    assign flip_req     = wr_ctrl && wdata[B_FLIP];
    assign stat_clr     = (wr && (addr == A_IRQ)) ? wdata[1:0] : 2'b00;
    assign irq_o        = |(irq_stat & irq_en);
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_en   <= 1'b0;
            pipe_on  <= 1'b1;
            hactive  <= '0;
            hlast    <= '0;
            hs_start <= '0;
            hs_end   <= '0;
            hs_en    <= 1'b0;
            hs_inv   <= 1'b0;
            vactive  <= '0;
            vlast    <= '0;
            vs_start <= '0;
            vs_end   <= '0;
            vs_en    <= 1'b0;
            vs_inv   <= 1'b0;
            base0    <= '0;
            base1    <= '0;
            irq_en   <= 2'b00;
            irq_stat <= 2'b00;
        end else begin
            if (wr) begin
                unique case (addr)
                    A_CTRL: begin
                        out_en  <= wdata[B_OUTEN];
                        pipe_on <= wdata[B_RUN];
                    end
                    A_HTIME: begin
                        hactive <= wdata[HW-1:0];
                        hlast   <= wdata[FIELD_HI +: HW];
                    end
                    A_VTIME: begin
                        vactive <= wdata[VW-1:0];
                        vlast   <= wdata[FIELD_HI +: VW];
                    end
                    A_HSYNC: begin
                        hs_start <= wdata[HW-1:0];
                        hs_end   <= wdata[FIELD_HI +: HW];
                        hs_en    <= wdata[B_SYNC_EN];
                        hs_inv   <= wdata[B_SYNC_INV];
                    end
                    A_VSYNC: begin
                        vs_start <= wdata[VW-1:0];
                        vs_end   <= wdata[FIELD_HI +: VW];
                        vs_en    <= wdata[B_SYNC_EN];
                        vs_inv   <= wdata[B_SYNC_INV];
                    end
                    A_BASE0: base0  <= wdata;
                    A_BASE1: base1  <= wdata;
                    A_IRQ:   irq_en <= wdata[FIELD_HI +: 2];
                    default: ;
                endcase
            end
            // a new event wins over a clearing write in the same cycle
            irq_stat <= soft_clr ? 2'b00 : ((irq_stat & ~stat_clr) | {vs_evt, hs_evt});
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: begin
                rdata[B_OUTEN] = out_en;
                rdata[B_RUN]   = pipe_on;
                rdata[B_SEL]   = sel;
                rdata[B_PEND]  = pending;
            end
            A_HTIME: begin
                rdata[HW-1:0]          = hactive;
                rdata[FIELD_HI +: HW]  = hlast;
            end
            A_VTIME: begin
                rdata[VW-1:0]          = vactive;
                rdata[FIELD_HI +: VW]  = vlast;
            end
            A_HSYNC: begin
                rdata[HW-1:0]          = hs_start;
                rdata[FIELD_HI +: HW]  = hs_end;
                rdata[B_SYNC_EN]       = hs_en;
                rdata[B_SYNC_INV]      = hs_inv;
            end
            A_VSYNC: begin
                rdata[VW-1:0]          = vs_start;
                rdata[FIELD_HI +: VW]  = vs_end;
                rdata[B_SYNC_EN]       = vs_en;
                rdata[B_SYNC_INV]      = vs_inv;
            end
            A_BASE0: rdata = base0;
            A_BASE1: rdata = base1;
            A_POS: begin
                rdata[FIELD_HI +: HW]  = pos_x;
                rdata[VW-1:0]          = pos_y;
            end
            A_VBCNT: rdata = vbcount;
            A_IRQ: begin
                rdata[1:0]             = irq_stat;
                rdata[FIELD_HI +: 2]   = irq_en;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/scan_pipe.sv
module scan_pipe
    import scan_pkg::*;
#(
    parameter int HW = 13,
    parameter int VW = 12,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              irq_o,
    output logic [DW-1:0]     fb_base_o
);
    logic          out_en, pipe_on, run, soft_clr, flip_req;
    logic [HW-1:0] hactive, hlast, hs_start, hs_end;
    logic [VW-1:0] vactive, vlast, vs_start, vs_end;
    logic          hs_en, hs_inv, vs_en, vs_inv;
    logic [DW-1:0] base0, base1, vbcount;
    logic [1:0]    irq_en, irq_stat;
    logic [HW-1:0] pos_x;
    logic [VW-1:0] pos_y;
    logic          hs_evt, vs_evt, vb_evt;
    logic          sel, pending;

    assign run       = out_en && pipe_on;
    assign fb_base_o = sel ? base1 : base0;

    scan_regs #(.HW(HW), .VW(VW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .pos_x(pos_x), .pos_y(pos_y), .sel(sel), .pending(pending),
        .vbcount(vbcount), .hs_evt(hs_evt), .vs_evt(vs_evt),
        .out_en(out_en), .pipe_on(pipe_on), .soft_clr(soft_clr),
        .flip_req(flip_req),
        .hactive(hactive), .hlast(hlast), .hs_start(hs_start),
        .hs_end(hs_end), .hs_en(hs_en), .hs_inv(hs_inv),
        .vactive(vactive), .vlast(vlast), .vs_start(vs_start),
        .vs_end(vs_end), .vs_en(vs_en), .vs_inv(vs_inv),
        .base0(base0), .base1(base1), .irq_en(irq_en),
        .irq_stat(irq_stat), .irq_o(irq_o)
    );

    scan_timing #(.HW(HW), .VW(VW), .CW(DW)) u_timing (
        .clk(clk), .rst_n(rst_n), .run(run), .soft_clr(soft_clr),
        .hactive(hactive), .hlast(hlast), .hs_start(hs_start),
        .hs_end(hs_end), .hs_en(hs_en), .hs_inv(hs_inv),
        .vactive(vactive), .vlast(vlast), .vs_start(vs_start),
        .vs_end(vs_end), .vs_en(vs_en), .vs_inv(vs_inv),
        .pos_x(pos_x), .pos_y(pos_y), .vbcount(vbcount),
        .hs_evt(hs_evt), .vs_evt(vs_evt), .vb_evt(vb_evt),
        .hsync(hsync_o), .vsync(vsync_o), .de(de_o)
    );

    scan_flip u_flip (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .flip_req(flip_req), .vb_evt(vb_evt),
        .sel(sel), .pending(pending)
    );
endmodule

// File: rtl/scan_pipe_chk.sv
module scan_pipe_chk #(
    parameter int HW = 13,
    parameter int VW = 12,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          soft_clr,
    input logic          vb_evt,
    input logic          sel,
    input logic          pending,
    input logic          out_en,
    input logic          hs_inv,
    input logic          hsync_o,
    input logic          irq_o,
    input logic [1:0]    irq_en,
    input logic [HW-1:0] pos_x,
    input logic [HW-1:0] hlast,
    input logic [VW-1:0] pos_y,
    input logic [DW-1:0] vbcount
);
    assert_x_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !soft_clr && pos_x == hlast) |=> (pos_x == '0));

    assert_sync_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (hsync_o == hs_inv));

    assert_vbcnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!vb_evt && !soft_clr) |=> $stable(vbcount));

    assert_vbcnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vb_evt && !soft_clr) |=> (vbcount == $past(vbcount) + 1'b1));

    assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!vb_evt && !soft_clr) |=> $stable(sel));

    assert_pend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !vb_evt && !soft_clr) |=> pending);

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 2'b00) |-> !irq_o);

    assert_pos_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !soft_clr) |=> ($stable(pos_x) && $stable(pos_y)));
endmodule

bind scan_pipe scan_pipe_chk #(.HW(HW), .VW(VW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .soft_clr(soft_clr),
    .vb_evt(vb_evt), .sel(sel), .pending(pending), .out_en(out_en),
    .hs_inv(hs_inv), .hsync_o(hsync_o), .irq_o(irq_o), .irq_en(irq_en),
    .pos_x(pos_x), .hlast(hlast), .pos_y(pos_y), .vbcount(vbcount)
);

// File: tb/test_scan_pipe.sv
`timescale 1ns/1ps
module test_scan_pipe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        hsync_o, vsync_o, de_o, irq_o;
    logic [31:0] fb_base_o;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] last_rd;

    // reference model state
    logic        m_outen, m_on, m_sel, m_pend;
    logic [12:0] m_x, m_hact, m_hlast, m_hss, m_hse;
    logic [11:0] m_y, m_vact, m_vlast, m_vss, m_vse;
    logic        m_hen, m_hinv, m_ven, m_vinv;
    logic [31:0] m_b0, m_b1, m_vb;
    logic [1:0]  m_ien, m_stat;

    scan_pipe i_scan_pipe (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .de_o(de_o), .irq_o(irq_o), .fb_base_o(fb_base_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic m_run();
        return m_outen && m_on;
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a)
            4'd0: return {27'd0, m_pend, m_sel, 1'b0, m_on, m_outen};
            4'd1: return {3'd0, m_hlast, 3'd0, m_hact};
            4'd2: return {4'd0, m_vlast, 4'd0, m_vact};
            4'd3: return {m_hinv, m_hen, 1'b0, m_hse, 3'd0, m_hss};
            4'd4: return {m_vinv, m_ven, 2'd0, m_vse, 4'd0, m_vss};
            4'd5: return m_b0;
            4'd6: return m_b1;
            4'd7: return {3'd0, m_x, 4'd0, m_y};
            4'd8: return m_vb;
            4'd9: return {14'd0, m_ien, 14'd0, m_stat};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] a);
        case (a)
            4'd0, 4'd5, 4'd6: return "R6 register";
            4'd3: return "R3 register";
            4'd4: return "R4 register";
            4'd7: return "R2 position";
            4'd8: return "R5 blank count";
            4'd9: return "R8 status";
            default: return "R2 register";
        endcase
    endfunction

    task automatic model_reset();
        m_outen = 0; m_on = 1; m_sel = 0; m_pend = 0;
        m_x = 0; m_hact = 0; m_hlast = 0; m_hss = 0; m_hse = 0;
        m_y = 0; m_vact = 0; m_vlast = 0; m_vss = 0; m_vse = 0;
        m_hen = 0; m_hinv = 0; m_ven = 0; m_vinv = 0;
        m_b0 = 0; m_b1 = 0; m_vb = 0; m_ien = 0; m_stat = 0;
    endtask

    task automatic model_step(input logic w, input logic [3:0] a, input logic [31:0] d);
        logic run, sclr, freq, hs_e, vs_e, vb, xw;
        logic [1:0] clr;
        run  = m_run();
        sclr = w && a == 4'd0 && m_on && !d[1];
        freq = w && a == 4'd0 && d[2];
        hs_e = run && m_x == m_hss;
        vs_e = run && m_x == 13'd0 && m_y == m_vss;
        xw   = (m_x == m_hlast);
        vb   = run && xw && ({1'b0, m_y} + 13'd1 == {1'b0, m_vact});
        clr  = (w && a == 4'd9) ? d[1:0] : 2'b00;
        if (sclr) begin
            m_x = 0; m_y = 0; m_vb = 0; m_sel = 0; m_pend = 0; m_stat = 0;
        end else begin
            if (run) begin
                if (xw) begin
                    m_x = 0;
                    m_y = (m_y == m_vlast) ? 12'd0 : m_y + 12'd1;
                end else begin
                    m_x = m_x + 13'd1;
                end
            end
            if (vb) m_vb = m_vb + 1;
            if (m_pend) begin
                if (vb) begin m_pend = 0; m_sel = ~m_sel; end
            end else if (freq) begin
                m_pend = 1;
            end
            m_stat = (m_stat & ~clr) | {vs_e, hs_e};
        end
        if (w) begin
            case (a)
                4'd0: begin m_outen = d[0]; m_on = d[1]; end
                4'd1: begin m_hact = d[12:0]; m_hlast = d[28:16]; end
                4'd2: begin m_vact = d[11:0]; m_vlast = d[27:16]; end
                4'd3: begin m_hss = d[12:0]; m_hse = d[28:16]; m_hen = d[30]; m_hinv = d[31]; end
                4'd4: begin m_vss = d[11:0]; m_vse = d[27:16]; m_ven = d[30]; m_vinv = d[31]; end
                4'd5: m_b0 = d;
                4'd6: m_b1 = d;
                4'd9: m_ien = d[17:16];
                default: ;
            endcase
        end
    endtask

    // one clock: drive at the falling edge, compare, advance the model
    task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d;
        #1;
        last_rd = reg_rdata;
        chk(reg_rdata, exp_read(a), req_of(a));
        chk(hsync_o, ((m_run() && m_hen && m_x >= m_hss && m_x < m_hse) ^ m_hinv), "R3 hsync");
        chk(vsync_o, ((m_run() && m_ven && m_y >= m_vss && m_y < m_vse) ^ m_vinv), "R4 vsync");
        chk(de_o, (m_run() && m_x < m_hact && m_y < m_vact), "R11 de");
        chk(irq_o, |(m_stat & m_ien), "R8 irq");
        chk(fb_base_o, m_sel ? m_b1 : m_b0, "R6 base");
        model_step(w, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'($urandom_range(0, 10)), 32'd0);
    endtask

    task automatic peek(input logic [3:0] a);
        cyc(1'b0, a, 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] pos_keep;
        logic        s0;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        peek(4'd0); chk(last_rd, 32'h2, "R1 control");
        peek(4'd7); chk(last_rd, 32'h0, "R1 position");
        peek(4'd8); chk(last_rd, 32'h0, "R1 blank count");
        peek(4'd9); chk(last_rd, 32'h0, "R1 status");
        chk(irq_o, 0, "R1 irq"); chk(de_o, 0, "R1 de"); chk(fb_base_o, 0, "R1 base");

        // program: 10 pixels x 7 lines
        cyc(1, 4'd1, {3'd0, 13'd9, 3'd0, 13'd6});
        cyc(1, 4'd2, {4'd0, 12'd6, 4'd0, 12'd4});
        cyc(1, 4'd3, {1'b0, 1'b1, 1'b0, 13'd9, 3'd0, 13'd7});
        cyc(1, 4'd4, {1'b1, 1'b1, 2'd0, 12'd6, 4'd0, 12'd5});
        cyc(1, 4'd5, 32'hA000_0000);
        cyc(1, 4'd6, 32'hB000_0000);
        cyc(1, 4'd9, 32'h0003_0000);
        cyc(1, 4'd0, 32'h3);
        idle(150);
        peek(4'd8); chk(last_rd != 0, 1, "R5 blanks counted");

        // R6: flip, then flip back
        peek(4'd0); s0 = last_rd[3];
        cyc(1, 4'd0, 32'h7);
        peek(4'd0); chk(last_rd[4], 1, "R6 pending set");
        idle(80);
        peek(4'd0); chk(last_rd[4:3], {1'b0, ~s0}, "R6 swapped");
        chk(fb_base_o, ~s0 ? 32'hB000_0000 : 32'hA000_0000, "R6 base switched");
        cyc(1, 4'd0, 32'h7);
        idle(80);
        peek(4'd0); chk(last_rd[3], s0, "R6 swapped back");

        // R7: repeated requests while pending make one swap
        cyc(1, 4'd0, 32'h7);
        cyc(1, 4'd0, 32'h7);
        cyc(1, 4'd0, 32'h7);
        idle(80);
        peek(4'd0); chk(last_rd[4:3], {1'b0, ~s0}, "R7 single swap");

        // R9: output enable cleared holds the raster
        cyc(1, 4'd0, 32'h2);
        peek(4'd7); pos_keep = last_rd;
        idle(20);
        peek(4'd7); chk(last_rd, pos_keep, "R9 position held");
        chk(hsync_o, 0, "R9 hsync idle"); chk(vsync_o, 1, "R9 vsync idle");
        cyc(1, 4'd0, 32'h3);
        idle(100);

        // R10: soft reset clears pipe state, keeps configuration
        cyc(1, 4'd0, 32'h1);
        peek(4'd7); chk(last_rd, 0, "R10 position cleared");
        peek(4'd8); chk(last_rd, 0, "R10 blank count cleared");
        peek(4'd0); chk(last_rd, 32'h1, "R10 control");
        peek(4'd5); chk(last_rd, 32'hA000_0000, "R10 base kept");
        idle(10);
        peek(4'd7); chk(last_rd, 0, "R10 held while off");
        cyc(1, 4'd1, {3'd0, 13'd12, 3'd0, 13'd9});
        cyc(1, 4'd2, {4'd0, 12'd9, 4'd0, 12'd7});
        cyc(1, 4'd0, 32'h3);

        // R2 R8: random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) == 0) begin
                int k;
                logic [3:0] a;
                logic [31:0] d;
                k = $urandom_range(0, 5);
                d = $urandom;
                case (k)
                    0: begin a = 4'd0; d = {29'd0, d[2], ($urandom_range(0, 9) != 0), ($urandom_range(0, 7) != 0)}; end
                    1: begin a = 4'd3; d = {d[31:30], 1'b0, 13'($urandom_range(0, 13)), 3'd0, 13'($urandom_range(0, 13))}; end
                    2: begin a = 4'd4; d = {d[31:30], 2'd0, 12'($urandom_range(0, 10)), 4'd0, 12'($urandom_range(0, 10))}; end
                    3: a = 4'd5;
                    4: a = 4'd6;
                    default: begin a = 4'd9; d = {14'd0, d[17:16], 14'd0, d[1:0]}; end
                endcase
                cyc(1'b1, a, d);
            end else begin
                idle(1);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule